// File: doc/BRIEF.md
# Software Sector-Protection Enable Sequencer

This block sits behind an SPI slave deserializer. It watches the bytes that arrive while chip select is low. If one frame carries exactly the four-byte enable command and nothing else, the block sets a software protection flag when chip select goes high again. Any other frame leaves the flag alone: a wrong byte, a missing byte or an extra byte. Only reset clears the flag.

The effective protection status is the software flag ORed with an active-low hardware write-protect pin. The pin passes through a two-flop synchronizer before it is used. A program or erase request names a sector. It is refused when protection is effective and that sector's bit is set in the protection mask, which comes from outside the block.

Top module: `prot_enable_seq`

## Requirements
- R1: A frame with cs_n low that carries exactly the bytes 0x3D, 0x2A, 0x7F, 0xA9 in that order sets the software flag. The flag sets on the second rising clock edge at which cs_n is sampled high, counting from the edge where cs_n is first sampled high, so prot_status rises after that edge.
- R2: If any byte in the frame differs from the expected byte at its position, the flag is left unchanged.
- R3: If a frame carries a fifth byte after the four correct ones, the flag is left unchanged.
- R4: If cs_n rises after fewer than four bytes, nothing is committed. A command split across two frames is also not committed.
- R5: Bytes presented while cs_n is high are ignored and do not count towards the sequence.
- R6: Once set, the software flag stays set until reset. Later frames and changes on the pin do not clear it.
- R7: wp_n is active low and passes through two flip-flops. prot_status follows a change on wp_n after the second rising edge and not after the first.
- R8: prot_status equals the software flag OR the synchronized, inverted wp_n.
- R9: req_permit is high exactly when req_vld is high and prot_status is not high while sect_mask bit req_sect is 1. A sector index at or beyond NSECT is refused.
- R10: Reset clears the software flag and the synchronizer (pin taken as released), so prot_status is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the SPI port, active low, synchronous to clk |
| byte_vld | input | 1 | A received byte is valid this cycle |
| byte_dat | input | 8 | Received byte |
| wp_n | input | 1 | Hardware write-protect pin, active low, asynchronous |
| sect_mask | input | NSECT | One bit per sector; 1 marks the sector as protectable |
| req_vld | input | 1 | A program or erase request is present |
| req_sect | input | SECT_W | Sector addressed by the request |
| prot_status | output | 1 | Effective protection status |
| req_permit | output | 1 | The request may proceed |

## Verification
The enable command is tried in several frames: a correct frame, frames with a wrong first or last byte, a frame with a trailing fifth byte, a truncated frame, a command split across two frames, and a command whose first bytes arrive while chip select is high. Only the correct frame may change the flag. The other frames separate an exact match from a prefix match, from counting bytes across frames, and from ignoring chip select. A behavioural model built on a byte queue is compared with both outputs on every clock. The pin and the mask are varied both with and without the software flag set, so the OR of the two sources and the per-sector gating are each exposed on their own.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

    localparam int CMD_LEN = 4;
    localparam int CNT_W   = $clog2(CMD_LEN + 1);

    // expected byte at each position of the enable command
    function automatic logic [7:0] cmd_byte(input logic [CNT_W-1:0] idx);
        case (idx)
            CNT_W'(0): cmd_byte = 8'h3D;
            CNT_W'(1): cmd_byte = 8'h2A;
            CNT_W'(2): cmd_byte = 8'h7F;
            CNT_W'(3): cmd_byte = 8'hA9;
            default:   cmd_byte = 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0] cnt;     // bytes matched so far in this frame
        logic             bad;     // frame already spoiled
        logic             cs_prev; // cs_n of the previous cycle
        logic             commit;  // one-cycle commit pulse
    } match_st_t;

endpackage

// File: rtl/cmd_matcher.sv
module cmd_matcher
    import prot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_dat,
    output logic       commit
);

    match_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        if (cs_n) begin
            // frame closes on the first cycle cs_n is seen high
            st_d.commit = !st_q.cs_prev && (st_q.cnt == CNT_W'(CMD_LEN)) && !st_q.bad;
            st_d.cnt    = '0;
            st_d.bad    = 1'b0;
        end else if (byte_vld) begin
            if (!st_q.bad && (st_q.cnt < CNT_W'(CMD_LEN)) && (byte_dat == cmd_byte(st_q.cnt)))
                st_d.cnt = st_q.cnt + CNT_W'(1);
            else
                st_d.bad = 1'b1;
        end
        st_d.cs_prev = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, bad: 1'b0, cs_prev: 1'b1, commit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign commit = st_q.commit;

    // R1
    commit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cs_n || $past(cs_n)) && !$past(st_q.cs_prev));

endmodule

// File: rtl/wp_sync.sv
module wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_n_s
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/sector_gate.sv
module sector_gate #(
    parameter int NSECT  = 64,
    parameter int SECT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_on,
    input  logic [NSECT-1:0]  sect_mask,
    input  logic              req_vld,
    input  logic [SECT_W-1:0] req_sect,
    output logic              req_permit
);

    localparam logic [SECT_W:0] NS_LIM = (SECT_W+1)'(NSECT);

    logic in_range;
    logic marked;

    always_comb begin
        in_range = {1'b0, req_sect} < NS_LIM;
        marked   = in_range ? sect_mask[req_sect] : 1'b0;
        req_permit = req_vld && in_range && !(prot_on && marked);
    end

    // R9
    permit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_permit |-> req_vld);

endmodule

// File: rtl/prot_enable_seq.sv
module prot_enable_seq
    import prot_seq_pkg::*;
#(
    parameter int NSECT     = 64,
    parameter int WP_STAGES = 2,
    localparam int SECT_W   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    input  logic              wp_n,
    input  logic [NSECT-1:0]  sect_mask,
    input  logic              req_vld,
    input  logic [SECT_W-1:0] req_sect,
    output logic              prot_status,
    output logic              req_permit
);

    logic commit;
    logic wp_n_s;
    logic sw_d, sw_q;

    cmd_matcher u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat),
        .commit   (commit)
    );

    wp_sync #(.STAGES(WP_STAGES)) u_wp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (wp_n),
        .pin_n_s (wp_n_s)
    );

    always_comb begin
        sw_d = sw_q | commit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= 1'b0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign prot_status = sw_q | ~wp_n_s;

    sector_gate #(.NSECT(NSECT), .SECT_W(SECT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_on    (prot_status),
        .sect_mask  (sect_mask),
        .req_vld    (req_vld),
        .req_sect   (req_sect),
        .req_permit (req_permit)
    );

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |=> sw_q);

    // R1
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_q) |-> $past(commit));

    // R7
    wp_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_s |-> prot_status);

endmodule

// File: tb/sim_prot_enable_seq.sv
module sim_prot_enable_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic        wp_n = 1'b1;
    logic [63:0] sect_mask = 64'h0;
    logic        req_vld = 1'b0;
    logic [5:0]  req_sect = 6'd0;
    logic        prot_status;
    logic        req_permit;

    int checks = 0;
    int errors = 0;
    bit run_cmp = 1'b0;

    always #10 clk = ~clk;

    prot_enable_seq u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .wp_n(wp_n), .sect_mask(sect_mask),
        .req_vld(req_vld), .req_sect(req_sect),
        .prot_status(prot_status), .req_permit(req_permit)
    );

    // behavioural reference model
    logic [7:0] m_q[$];
    bit m_sw, m_commit, m_csp, m_w1, m_w2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sw = 0; m_commit = 0; m_csp = 1; m_w1 = 1; m_w2 = 1;
            m_q.delete();
        end else begin
            m_sw = m_sw | m_commit;
            m_commit = !m_csp && cs_n && m_q.size() == 4 && m_q[0] == 8'h3D &&
                       m_q[1] == 8'h2A && m_q[2] == 8'h7F && m_q[3] == 8'hA9;
            if (cs_n) m_q.delete();
            else if (byte_vld) m_q.push_back(byte_dat);
            m_csp = cs_n;
            m_w2 = m_w1;
            m_w1 = wp_n;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (rst_n && run_cmp) begin
            logic es, ep;
            es = m_sw | ~m_w2;
            ep = req_vld & ~(es & sect_mask[req_sect]);
            chk("R8 model status", prot_status, es);
            chk("R9 model permit", req_permit, ep);
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [7:0] tx[$];

    // sends tx inside one cs_n-low frame, leaves cs_n high at a negedge
    task automatic frame();
        @(negedge clk); cs_n = 1'b0;
        foreach (tx[i]) begin
            @(negedge clk); byte_vld = 1'b1; byte_dat = tx[i];
            @(negedge clk); byte_vld = 1'b0;
        end
        @(negedge clk); cs_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        run_cmp = 1'b1;
        settle(1);
        chk("R10 reset status", prot_status, 1'b0);
        chk("R10 reset permit idle", req_permit, 1'b0);

        tx = '{8'h3C, 8'h2A, 8'h7F, 8'hA9}; frame(); settle(3);
        chk("R2 wrong first byte", prot_status, 1'b0);
        tx = '{8'h3D, 8'h2A, 8'h7F, 8'hA8}; frame(); settle(3);
        chk("R2 wrong last byte", prot_status, 1'b0);
        tx = '{8'h3D, 8'h2A, 8'h7F, 8'hA9, 8'h00}; frame(); settle(3);
        chk("R3 fifth byte", prot_status, 1'b0);
        tx = '{8'h3D, 8'h2A, 8'h7F}; frame(); settle(3);
        chk("R4 three bytes", prot_status, 1'b0);
        tx = '{8'h3D, 8'h2A}; frame();
        tx = '{8'h7F, 8'hA9}; frame(); settle(3);
        chk("R4 split frames", prot_status, 1'b0);

        @(negedge clk); byte_vld = 1'b1; byte_dat = 8'h3D;
        @(negedge clk); byte_dat = 8'h2A;
        @(negedge clk); byte_vld = 1'b0;
        tx = '{8'h7F, 8'hA9}; frame(); settle(3);
        chk("R5 bytes with cs high", prot_status, 1'b0);

        // pin with flag clear
        sect_mask = 64'h0000_0000_0000_00F0;
        @(negedge clk); wp_n = 1'b0;
        settle(1); chk("R7 pin after one edge", prot_status, 1'b0);
        settle(1); chk("R7 pin after two edges", prot_status, 1'b1);
        @(negedge clk); req_vld = 1'b1; req_sect = 6'd5;
        settle(0); chk("R9 masked sector blocked", req_permit, 1'b0);
        @(negedge clk); req_sect = 6'd2;
        settle(0); chk("R9 unmasked sector allowed", req_permit, 1'b1);
        @(negedge clk); wp_n = 1'b1; req_sect = 6'd5;
        settle(1); chk("R7 release after one edge", prot_status, 1'b1);
        settle(1); chk("R7 release after two edges", prot_status, 1'b0);
        chk("R9 masked sector open when unprotected", req_permit, 1'b1);
        @(negedge clk); req_vld = 1'b0;

        // correct command
        tx = '{8'h3D, 8'h2A, 8'h7F, 8'hA9}; frame();
        settle(1); chk("R1 not yet after first high edge", prot_status, 1'b0);
        settle(1); chk("R1 set after second high edge", prot_status, 1'b1);
        chk("R8 flag alone drives status", prot_status, 1'b1);
        @(negedge clk); req_vld = 1'b1; req_sect = 6'd6;
        settle(0); chk("R9 flag blocks masked sector", req_permit, 1'b0);
        @(negedge clk); req_sect = 6'd8;
        settle(0); chk("R9 flag allows unmasked sector", req_permit, 1'b1);
        @(negedge clk); req_vld = 1'b0;

        tx = '{8'h00, 8'h11}; frame(); settle(3);
        chk("R6 bad frame keeps flag", prot_status, 1'b1);
        @(negedge clk); wp_n = 1'b0;
        settle(3);
        @(negedge clk); wp_n = 1'b1;
        settle(4); chk("R6 pin toggle keeps flag", prot_status, 1'b1);

        run_cmp = 1'b0;
        do_reset();
        run_cmp = 1'b1;
        settle(1); chk("R10 reset clears flag", prot_status, 1'b0);
        settle(5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule